// File: doc/BRIEF.md
# Delay-Slot Next-PC and Branch Resolution Unit

This block decides where an in-order 32-bit core fetches next when the instruction set uses one architectural delay slot. Each accepted instruction brings its own address, a decoded control-transfer code, the two source register values, a 16-bit branch displacement and a 26-bit jump field. There are no condition flags. Every branch condition comes straight from the register values: an equality or inequality test between two registers, or a signed test of one register against zero.

When a transfer is taken, the next fetch is still the sequential slot instruction. The resolved target is parked in a one-entry pending register. The slot instruction, when it is accepted, then sends fetch to the target and not to its own successor. The call forms report a write of the return address, which is the branch address plus 8, into register 31. The stall input freezes the pending state. An empty cycle (valid low) also leaves the pending state in place.

Top module: `dslot_next_pc`

## Requirements
- R1: After reset no target is pending: with valid low and a non-transfer code, next_pc equals pc+4, and taken and link_we are 0.
- R2: Code 1 is taken when rs_val equals rt_val. Code 2 is taken when they differ.
- R3: Codes 3, 4, 5 and 6 test rs_val as a signed two's-complement number, with the tests <=0, >0, <0 and >=0 in that order. Codes 7 and 8 use the tests <0 and >=0.
- R4: The target of a conditional branch is pc+4 plus the sign-extended displacement shifted left by 2. The addition wraps modulo 2^32.
- R5: Codes 9 (plain jump) and 10 (jump with link) target {pc+4 bits 31:28, jump field, 2'b00}. The top bits come from pc+4, not from pc.
- R6: Code 11 targets rs_val unchanged.
- R7: Codes 7, 8 and 10 raise link_we with link_val = pc+8 and link_idx = 31. For codes 7 and 8 this happens whether or not the branch is taken. No other code raises link_we.
- R8: In the cycle that a taken transfer is accepted, next_pc is pc+4. When the following instruction is accepted, next_pc is the resolved target. A not-taken branch leaves sequential flow.
- R9: An instruction accepted while a target is pending is a delay-slot instruction. Its own transfer code is ignored: taken and link_we stay 0 and next_pc is the pending target. Afterwards flow continues at the target.
- R10: While stall is 1, or valid is 0, no transfer is captured and a pending target is kept. The target is released only when a valid instruction is accepted without stall.
- R11: Code 0 and codes 12 to 15 are non-transfer codes. They have taken 0, link_we 0 and next_pc = pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold: no instruction is accepted this cycle |
| valid | input | 1 | An instruction is presented |
| xfer_op | input | 4 | Decoded control-transfer code |
| pc | input | 32 | Address of the presented instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_disp | input | 16 | Branch displacement in instructions |
| jmp_field | input | 26 | Jump target field |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | The presented transfer is taken |
| link_we | output | 1 | Write the return address |
| link_val | output | 32 | Return address |
| link_idx | output | 5 | Destination register of the return address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 5-bit register index, 16-bit displacement and 26-bit jump field. At these widths the displacement can cross zero and wrap the whole address space (0x8000 from a low pc). A jump placed just below a 256 MB boundary then shows that the region comes from pc+4. Each table entry is followed by a delay-slot cycle, so both the capture of the target and its release at the slot instruction are observed. Directed sequences put a call in the delay slot and mix stall cycles and empty cycles around a pending target.

// File: rtl/dslot_next_pc.sv
module dslot_next_pc #(
  parameter int AW       = 32,
  parameter int RIDX_W   = 5,
  parameter int DISP_W   = 16,
  parameter int JF_W     = 26,
  parameter int OP_W     = 4,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              valid,
  input  logic [OP_W-1:0]   xfer_op,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     rs_val,
  input  logic [AW-1:0]     rt_val,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [JF_W-1:0]   jmp_field,
  output logic [AW-1:0]     next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [AW-1:0]     link_val,
  output logic [RIDX_W-1:0] link_idx
);

  localparam int REGION_W = AW - JF_W - 2;

  localparam logic [OP_W-1:0] OP_BEQ    = OP_W'(1);
  localparam logic [OP_W-1:0] OP_BNE    = OP_W'(2);
  localparam logic [OP_W-1:0] OP_BLEZ   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_BGTZ   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_BLTZ   = OP_W'(5);
  localparam logic [OP_W-1:0] OP_BGEZ   = OP_W'(6);
  localparam logic [OP_W-1:0] OP_BLTZL  = OP_W'(7);
  localparam logic [OP_W-1:0] OP_BGEZL  = OP_W'(8);
  localparam logic [OP_W-1:0] OP_JMP    = OP_W'(9);
  localparam logic [OP_W-1:0] OP_JMPL   = OP_W'(10);
  localparam logic [OP_W-1:0] OP_JREG   = OP_W'(11);

  logic          pend_vld;
  logic [AW-1:0] pend_tgt;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] jmp_tgt;
  logic [AW-1:0] disp_ext;
  logic          rs_neg, rs_zero, regs_eq;
  logic          cond;
  logic          links;
  logic [AW-1:0] xfer_tgt;
  logic          accept;

  assign seq_pc   = pc + AW'(4);
  assign disp_ext = {{(AW-DISP_W-2){br_disp[DISP_W-1]}}, br_disp, 2'b00};
  assign br_tgt   = seq_pc + disp_ext;
  assign jmp_tgt  = {seq_pc[AW-1 -: REGION_W], jmp_field, 2'b00};

  assign rs_neg   = rs_val[AW-1];
  assign rs_zero  = (rs_val == '0);
  assign regs_eq  = (rs_val == rt_val);

  always_comb begin
    cond     = 1'b0;
    links    = 1'b0;
    xfer_tgt = br_tgt;
    unique case (xfer_op)
      OP_BEQ:   cond = regs_eq;
      OP_BNE:   cond = !regs_eq;
      OP_BLEZ:  cond = rs_neg || rs_zero;
      OP_BGTZ:  cond = !rs_neg && !rs_zero;
      OP_BLTZ:  cond = rs_neg;
      OP_BGEZ:  cond = !rs_neg;
      OP_BLTZL: begin cond = rs_neg;  links = 1'b1; end
      OP_BGEZL: begin cond = !rs_neg; links = 1'b1; end
      OP_JMP:   begin cond = 1'b1; xfer_tgt = jmp_tgt; end
      OP_JMPL:  begin cond = 1'b1; links = 1'b1; xfer_tgt = jmp_tgt; end
      OP_JREG:  begin cond = 1'b1; xfer_tgt = rs_val; end
      default:  cond = 1'b0;
    endcase
  end

  assign accept   = valid && !stall;
  assign taken    = valid && !pend_vld && cond;
  assign link_we  = valid && !pend_vld && links;
  assign link_val = pc + AW'(8);
  assign link_idx = RIDX_W'(LINK_REG);
  assign next_pc  = pend_vld ? pend_tgt : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_tgt <= '0;
    end else if (accept) begin
      if (pend_vld) begin
        pend_vld <= 1'b0;
      end else if (cond) begin
        pend_vld <= 1'b1;
        pend_tgt <= xfer_tgt;
      end
    end
  end

  AST_TAKEN_SLOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_pc == pc + AW'(4)); // R8

  AST_SLOT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(taken) && $past(!stall)) |-> (!taken && !link_we)); // R9

  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_val == pc + AW'(8) && link_idx == RIDX_W'(LINK_REG))); // R7

  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !valid) |=> ($stable(pend_vld) && $stable(pend_tgt))); // R10

  AST_NOXFER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (xfer_op == '0) && !pend_vld) |-> (!taken && !link_we)); // R11

endmodule

// File: tb/tb_dslot_next_pc.sv
module tb_dslot_next_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  xfer_op = '0;
  logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dslot_next_pc dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .valid(valid), .xfer_op(xfer_op),
    .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .br_disp(br_disp),
    .jmp_field(jmp_field), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_val(link_val), .link_idx(link_idx)
  );

  localparam int NV = 13;
  localparam logic [3:0]  V_OP [NV] = '{4'd1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
                                        4'd9, 4'd11, 4'd0, 4'd7, 4'd8, 4'd10};
  localparam logic [31:0] V_PC [NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h3000, 32'h3000,
                                        32'h4000, 32'h5000, 32'h8FFF_FFFC, 32'h100, 32'h200,
                                        32'h600, 32'h700, 32'h800};
  localparam logic [31:0] V_RS [NV] = '{32'd5, 32'd5, 32'd1, 32'd0, 32'd0, 32'hFFFF_FFFF,
                                        32'h8000_0000, 32'd0, 32'hABC0, 32'd0, 32'd1,
                                        32'd0, 32'd0};
  localparam logic [31:0] V_RT [NV] = '{32'd5, 32'd6, 32'd2, 32'd0, 32'd0, 32'd0, 32'd0,
                                        32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
  localparam logic [15:0] V_DS [NV] = '{16'h0004, 16'h0004, 16'hFFFF, 16'h0010, 16'h0010,
                                        16'h8000, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h0005,
                                        16'h0002, 16'h0};
  localparam logic [25:0] V_JF [NV] = '{26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0,
                                        26'h3FF_FFFF, 26'h0, 26'h0, 26'h0, 26'h0, 26'h100};
  localparam logic        V_TK [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                                        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic        V_LK [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_NX [NV] = '{32'h1014, 32'h1008, 32'h2000, 32'h3044, 32'h3008,
                                        32'hFFFE_4004, 32'h5008, 32'h9FFF_FFFC, 32'hABC0,
                                        32'h208, 32'h608, 32'h70C, 32'h400};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] op, input logic [31:0] a, input logic [31:0] r1,
                     input logic [31:0] r2, input logic [15:0] d, input logic [25:0] j,
                     input logic v, input logic s);
    @(negedge clk);
    xfer_op = op; pc = a; rs_val = r1; rt_val = r2; br_disp = d; jmp_field = j;
    valid = v; stall = s;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    put(4'd0, 32'h40, 0, 0, 0, 0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    put(4'd0, 32'h40, 0, 0, 0, 0, 1'b0, 1'b0);
    chk("R1 next_pc", next_pc, 32'h44);
    chk("R1 taken", {31'd0, taken}, 32'd0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      put(V_OP[i], V_PC[i], V_RS[i], V_RT[i], V_DS[i], V_JF[i], 1'b1, 1'b0);
      chk($sformatf("R2/R3/R8 taken v%0d", i), {31'd0, taken}, {31'd0, V_TK[i]});
      chk($sformatf("R8 slot fetch v%0d", i), next_pc, V_PC[i] + 32'd4);
      chk($sformatf("R7/R11 link_we v%0d", i), {31'd0, link_we}, {31'd0, V_LK[i]});
      if (V_LK[i]) begin
        chk($sformatf("R7 link_val v%0d", i), link_val, V_PC[i] + 32'd8);
        chk($sformatf("R7 link_idx v%0d", i), {27'd0, link_idx}, 32'd31);
      end
      put(4'd0, V_PC[i] + 32'd4, 0, 0, 0, 0, 1'b1, 1'b0);
      chk($sformatf("R4/R5/R6/R8 follow v%0d", i), next_pc, V_NX[i]);
      chk($sformatf("R9 slot not taken v%0d", i), {31'd0, taken}, 32'd0);
    end

    put(4'd13, 32'hC00, 32'd0, 32'd0, 16'h0001, 26'h1, 1'b1, 1'b0);
    chk("R11 code13 taken", {31'd0, taken}, 32'd0);
    chk("R11 code13 next_pc", next_pc, 32'hC04);

    put(4'd1, 32'hA00, 32'd0, 32'd0, 16'h0001, 26'h0, 1'b1, 1'b0);
    chk("R2 beq zero regs", {31'd0, taken}, 32'd1);
    put(4'd10, 32'hA04, 32'd0, 32'd0, 16'h0, 26'h3, 1'b1, 1'b0);
    chk("R9 slot jal taken", {31'd0, taken}, 32'd0);
    chk("R9 slot jal link_we", {31'd0, link_we}, 32'd0);
    chk("R9 slot next_pc", next_pc, 32'hA08);
    put(4'd0, 32'hA08, 0, 0, 0, 0, 1'b1, 1'b0);
    chk("R9 after slot", next_pc, 32'hA0C);

    put(4'd2, 32'hB00, 32'd1, 32'd0, 16'h0003, 26'h0, 1'b1, 1'b1);
    chk("R10 stalled branch taken", {31'd0, taken}, 32'd1);
    put(4'd2, 32'hB00, 32'd1, 32'd0, 16'h0003, 26'h0, 1'b1, 1'b0);
    chk("R10 stall did not capture", {31'd0, taken}, 32'd1);
    chk("R10 branch slot fetch", next_pc, 32'hB04);
    put(4'd0, 32'hB04, 0, 0, 0, 0, 1'b0, 1'b0);
    chk("R10 bubble keeps target", next_pc, 32'hB10);
    put(4'd0, 32'hB04, 0, 0, 0, 0, 1'b1, 1'b1);
    chk("R10 stall keeps target", next_pc, 32'hB10);
    put(4'd0, 32'hB04, 0, 0, 0, 0, 1'b1, 1'b0);
    chk("R10 release target", next_pc, 32'hB10);
    put(4'd0, 32'hB10, 0, 0, 0, 0, 1'b1, 1'b0);
    chk("R10 sequential after", next_pc, 32'hB14);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule